// File: doc/BRIEF.md
# Watchdog Failover Controller for a Duplicated Processor Pair

This block watches over two processors, a primary (A) and a spare (B), with one restartable down-counter. Only the processor that currently owns the system bus can restart the counter. It does so by pulsing its kick input. If that processor stops kicking and the counter runs out, the controller takes the bus grant away from it. It then gives the grant to the spare and lights a CPU fault lamp.

When the spare restarts the counter for the first time, the lamp goes dark again. If the spare also lets the counter run out, the controller removes both grants. It keeps the lamp lit until a reset. Control never goes back to the primary on its own. The timeout length comes from an input. That value is loaded at reset, on every honoured kick and at the moment of failover.

Top module: `wdf_failover_ctrl`

## Requirements
- R1: While reset is held and after its release, processor A owns the bus: `sel_b`=0, `grant_a`=1, `grant_b`=0, `fault_led`=0.
- R2: With a timeout value T, honoured kicks spaced at most T+1 clock edges apart keep the current owner in control indefinitely.
- R3: With no honoured kick, failover happens exactly on the (T+1)th rising edge after reset release or after the last honoured kick. From then on `sel_b`=1, `grant_a`=0, `grant_b`=1 and `fault_led`=1.
- R4: A kick from the processor that does not own the bus has no effect on the counter or the state.
- R5: The first honoured kick from B after a failover turns `fault_led` off on that edge, and B keeps the grant.
- R6: If B also misses its window, both grants drop and `fault_led` is lit. This dual-failure state ignores all kicks until reset.
- R7: Once `sel_b` is 1 it stays 1 until reset, whatever A does.
- R8: The counter is reloaded at failover, so B gets a full window of T+1 edges before the dual-failure state.
- R9: Each reload takes the `timeout_val` present at that edge, so a new value applies from the next honoured kick.
- R10: At most one grant is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick_a | input | 1 | Counter restart strobe from processor A |
| kick_b | input | 1 | Counter restart strobe from processor B |
| timeout_val | input | CNT_W | Number of idle edges allowed before expiry, minus one |
| sel_b | output | 1 | 0: A owns the bus, 1: B owns it |
| grant_a | output | 1 | Bus enable for processor A |
| grant_b | output | 1 | Bus enable for processor B |
| fault_led | output | 1 | CPU fault indicator |

## Verification
The bench builds the block with a 4-bit counter (CNT_W=4). This keeps every timeout short enough to sweep all values from 0 to 7 within one run. For each value it measures the exact edge of failover and the exact edge of the dual failure, so off-by-one errors in the reload or in the expiry test show up as a wrong edge count. Further runs apply kicks at the longest legal spacing and hold the non-owner's kick high. They also retime the timeout value between kicks, which exercises the ignore rule, the fault-clear edge and the reload sampling.

// File: rtl/wdf_pkg.sv
// Shared types for the watchdog failover controller.
package wdf_pkg;
    // Ownership and health of the processor pair.
    typedef enum logic [1:0] {
        ST_A_RUN    = 2'd0,  // primary owns the bus
        ST_B_PEND   = 2'd1,  // spare owns the bus, fault lamp lit
        ST_B_RUN    = 2'd2,  // spare owns the bus and has proven alive
        ST_DEAD     = 2'd3   // both failed, latched until reset
    } wdf_state_e;
endpackage

// File: rtl/wdf_timer.sv
// Restartable down-counter.
// Assumes: reload has priority over counting; the counter stops at zero.
// expired is high while the count equals zero.
module wdf_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload,
    input  logic             run,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    // Load at reset or on request, otherwise count down to zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= load_val;
        end else if (reload) begin
            count_q <= load_val;
        end else if (run && (count_q != ZERO)) begin
            count_q <= count_q - ONE;
        end
    end

    // Zero detect.
    always_comb begin
        expired = (count_q == ZERO);
    end
endmodule

// File: rtl/wdf_kick_sel.sv
// Passes on the kick of the bus owner only.
// Assumes: state encoding from wdf_pkg; in the dual-failure state no kick counts.
module wdf_kick_sel
    import wdf_pkg::*;
(
    input  wdf_state_e state,
    input  logic       kick_a,
    input  logic       kick_b,
    output logic       kick_ok
);
    // Choose the strobe that belongs to the current owner.
    always_comb begin
        unique case (state)
            ST_A_RUN:           kick_ok = kick_a;
            ST_B_PEND, ST_B_RUN: kick_ok = kick_b;
            default:            kick_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdf_fsm.sv
// Ownership state machine of the failover controller.
// Assumes: expired and kick_ok are from the same cycle; a kick wins over expiry.
// Requests a timer reload on every honoured kick and on failover to the spare.
module wdf_fsm
    import wdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick_ok,
    input  logic       expired,
    output wdf_state_e state,
    output logic       reload,
    output logic       run
);
    wdf_state_e state_q;
    wdf_state_e state_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_A_RUN:  if (!kick_ok && expired) state_d = ST_B_PEND;
            ST_B_PEND: begin
                if (kick_ok)      state_d = ST_B_RUN;
                else if (expired) state_d = ST_DEAD;
            end
            ST_B_RUN:  if (!kick_ok && expired) state_d = ST_DEAD;
            default:   state_d = ST_DEAD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_A_RUN;
        else        state_q <= state_d;
    end

    // Timer control derived from the decision.
    always_comb begin
        state  = state_q;
        reload = kick_ok || ((state_q == ST_A_RUN) && (state_d == ST_B_PEND));
        run    = (state_q != ST_DEAD);
    end
endmodule

// File: rtl/wdf_failover_ctrl.sv
// Top of the watchdog failover controller.
// Assumes: kicks are synchronous to clk; timeout_val is stable around reload edges.
// Outputs are decoded from the registered state only.
module wdf_failover_ctrl
    import wdf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_a,
    input  logic             kick_b,
    input  logic [CNT_W-1:0] timeout_val,
    output logic             sel_b,
    output logic             grant_a,
    output logic             grant_b,
    output logic             fault_led
);
    wdf_state_e state;
    logic       kick_ok;
    logic       expired;
    logic       reload;
    logic       run;

    wdf_kick_sel u_kick (
        .state   (state),
        .kick_a  (kick_a),
        .kick_b  (kick_b),
        .kick_ok (kick_ok)
    );

    wdf_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick_ok (kick_ok),
        .expired (expired),
        .state   (state),
        .reload  (reload),
        .run     (run)
    );

    wdf_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (timeout_val),
        .reload   (reload),
        .run      (run),
        .expired  (expired)
    );

    // Output decode.
    always_comb begin
        sel_b     = (state != ST_A_RUN);
        grant_a   = (state == ST_A_RUN);
        grant_b   = (state == ST_B_PEND) || (state == ST_B_RUN);
        fault_led = (state == ST_B_PEND) || (state == ST_DEAD);
    end
endmodule

// File: rtl/wdf_failover_chk.sv
// Property checker for the watchdog failover controller, bound to the top.
module wdf_failover_chk (
    input logic clk,
    input logic rst_n,
    input logic kick_b,
    input logic sel_b,
    input logic grant_a,
    input logic grant_b,
    input logic fault_led
);
    // R10: never two grants at once
    a_r10_grants_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_a, grant_b}));

    // R7: spare ownership is permanent until reset
    a_r7_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        sel_b |=> sel_b);

    // R6: dual failure is latched with the lamp lit
    a_r6_dead_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_a && !grant_b) |=> (!grant_a && !grant_b && fault_led));

    // R3: failover always brings the spare grant and the lamp
    a_r3_failover_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_b) |-> (fault_led && grant_b && !grant_a));

    // R5: a spare kick while the lamp is lit clears it
    a_r5_lamp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_b && fault_led && kick_b) |=> (!fault_led && grant_b));
endmodule

bind wdf_failover_ctrl wdf_failover_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_b    (kick_b),
    .sel_b     (sel_b),
    .grant_a   (grant_a),
    .grant_b   (grant_b),
    .fault_led (fault_led)
);

// File: tb/wdf_failover_ctrl_tb.sv
module wdf_failover_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int WD_LIMIT   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             kick_a = 1'b0;
    logic             kick_b = 1'b0;
    logic [CNT_W-1:0] timeout_val = '0;
    logic             sel_b, grant_a, grant_b, fault_led;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    wdf_failover_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .kick_a(kick_a), .kick_b(kick_b),
        .timeout_val(timeout_val), .sel_b(sel_b), .grant_a(grant_a),
        .grant_b(grant_b), .fault_led(fault_led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still summarised.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Compare packed outputs {sel_b, grant_a, grant_b, fault_led}.
    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {sel_b, grant_a, grant_b, fault_led};
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %b expected %b (sel,ga,gb,led)", req, act, exp);
        end
    endtask

    localparam logic [3:0] O_A    = 4'b0100;
    localparam logic [3:0] O_BPND = 4'b1011;
    localparam logic [3:0] O_BOK  = 4'b1010;
    localparam logic [3:0] O_DEAD = 4'b1001;

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input int t);
        @(negedge clk);
        rst_n = 1'b0;
        kick_a = 1'b0;
        kick_b = 1'b0;
        timeout_val = CNT_W'(t);
        step(2);
        chk("R1 during reset", O_A);
        rst_n = 1'b1;
    endtask

    // One kick edge; returns at the negedge after it.
    task automatic pulse(input bit on_b);
        if (on_b) kick_b = 1'b1; else kick_a = 1'b1;
        step(1);
        kick_a = 1'b0;
        kick_b = 1'b0;
    endtask

    initial begin
        // R3/R8/R6/R1: sweep every short timeout
        for (int t = 0; t < 8; t++) begin
            do_reset(t);
            chk("R1 after release", O_A);
            step(t);
            chk("R3 no early failover", O_A);
            step(1);
            chk("R3 failover at edge T+1", O_BPND);
            step(t);
            chk("R8 spare full window", O_BPND);
            step(1);
            chk("R6 dual failure at edge T+1", O_DEAD);
            pulse(1'b1);
            pulse(1'b0);
            step(3);
            chk("R6 dead ignores kicks", O_DEAD);
        end

        // R2: A kicks at the longest legal spacing
        do_reset(4);
        step(4);
        for (int k = 0; k < 10; k++) begin
            pulse(1'b0);
            step(4);
            chk("R2 owner kept alive", O_A);
        end
        step(1);
        chk("R3 failover after last kick", O_BPND);

        // R4: non-owner kicks held high do not delay expiry
        do_reset(4);
        kick_b = 1'b1;
        step(4);
        chk("R4 B kick ignored while A owns", O_A);
        kick_b = 1'b0;
        step(1);
        chk("R4 expiry unchanged by B kicks", O_BPND);

        // R4/R7: A kicks ignored in spare ownership, R5 lamp clear
        kick_a = 1'b1;
        step(3);
        chk("R7 A kick does not reclaim bus", O_BPND);
        kick_a = 1'b0;
        pulse(1'b1);
        chk("R5 first spare kick clears lamp", O_BOK);
        for (int k = 0; k < 4; k++) begin
            kick_a = 1'b1;
            step(4);
            kick_a = 1'b0;
            chk("R7 spare keeps bus", O_BOK);
            pulse(1'b1);
        end
        kick_a = 1'b1;
        step(4);
        chk("R4 A kicks do not feed spare timer", O_BOK);
        step(1);
        kick_a = 1'b0;
        chk("R6 spare timeout after clear", O_DEAD);

        // R9: a new timeout value applies from the next reload
        do_reset(3);
        step(2);
        timeout_val = CNT_W'(6);
        pulse(1'b0);
        step(6);
        chk("R9 longer window after reload", O_A);
        step(1);
        chk("R9 expiry at new T+1", O_BPND);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule